// File: doc/BRIEF.md
# Event Readout Gate Sequencer

This block turns one accepted master trigger into the set of interlocked gates that govern digitization and readout of a single event. On acceptance it pulls three gates low at once: a trigger veto, an ADC conversion gate and a TDC gate. The TDC gate is both the common stop and the time-stamp latch. The ADC gate runs for a programmed number of cycles. When it ends, a FIFO-protect gate takes over and covers the readout. The TDC gate runs on for a short programmed extension past the ADC gate.

Readout completion comes from outside. A dead-time-end strobe or a last-pass strobe releases the FIFO gate, whichever arrives first. The veto is held until a fixed 1 µs tail has elapsed after the last-pass strobe, and that tail is a cycle count derived from the clock frequency. A programmable watchdog ends an event whose last-pass strobe never arrives. It releases every gate and flags the error. All gate outputs are active-low. The three input strobes are active-high and one cycle wide.

Top module: `evgate_seq`

## Requirements
- R1: After reset, all four gate outputs are high (released) and the error flag is low.
- R2: A trigger sampled high while the veto is released is accepted. In the next cycle the veto, ADC and TDC outputs go low together.
- R3: The ADC gate stays low for exactly max(W,1) cycles, where W is the ADC width input.
- R4: The TDC gate goes low with the ADC gate. It stays low for max(E,1) cycles after the ADC gate releases, where E is the extension input.
- R5: The FIFO gate goes low in the first cycle after the ADC gate releases. It stays low until a last-pass or dead-time-end strobe is sampled while it is low, and releases in the following cycle.
- R6: A last-pass or dead-time-end strobe sampled before the ADC gate has released has no effect.
- R7: The veto releases TAIL cycles after the edge that accepts the last-pass strobe, with TAIL = CLK_MHZ·TAIL_NS/1000 (10 in the bench). It never releases while the TDC gate is still low.
- R8: A trigger sampled while the veto is low is ignored. It neither restarts nor extends any gate.
- R9: For a nonzero limit L, if no last-pass strobe is accepted within L edges after the accepting edge, all gates release and the error flag goes high in the cycle after edge L. A last-pass strobe on edge L itself wins over the watchdog. The flag clears on the next accepted trigger, and L = 0 disables the watchdog.
- R10: A dead-time-end strobe releases only the FIFO gate. The veto still waits for the last-pass strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Master trigger strobe |
| last_pass_i | input | 1 | Readout-finished strobe |
| dt_end_i | input | 1 | Dead-time-end strobe |
| adc_width_i | input | CNT_W | ADC gate width in cycles (0 counts as 1) |
| tdc_ext_i | input | CNT_W | TDC extension past ADC end (0 counts as 1) |
| wdog_limit_i | input | WD_W | Watchdog limit in cycles (0 disables) |
| veto_n_o | output | 1 | Trigger veto, active low |
| adc_gate_n_o | output | 1 | ADC conversion gate, active low |
| tdc_gate_n_o | output | 1 | TDC stop / latch gate, active low |
| fifo_gate_n_o | output | 1 | Readout-protect gate, active low |
| wdog_err_o | output | 1 | Watchdog abort flag |

## Verification
The bench builds the block with CLK_MHZ = 10, which makes the veto tail ten cycles. That keeps the release of the veto inside a 60-cycle observation window for each event. This short tail lets one event end with the TDC extension still running after the tail has elapsed, so the bench can see the veto held by the TDC gate. A 12-bit watchdog limit keeps the abort and the tie between the watchdog and the last-pass strobe at cycle counts the bench can reach quickly. The 8-bit width inputs allow the zero-width clamp to be exercised directly.

// File: rtl/evgate_pkg.sv
package evgate_pkg;

   // Converts a duration in nanoseconds into whole clock cycles.
   function automatic int unsigned ns_to_cycles(int unsigned clk_mhz, int unsigned dur_ns);
      return (clk_mhz * dur_ns) / 1000;
   endfunction

   // One bit per gate, active high inside the block.
   typedef struct packed {
      logic veto;
      logic adc;
      logic tdc;
      logic fifo;
   } gate_set_t;

endpackage

// File: rtl/evgate_timer.sv
module evgate_timer #(
   parameter int W         = 8,
   parameter bit CLAMP_MIN = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic         clr_i,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         busy_o,
   output logic         last_o
);

   logic [W-1:0] cnt_q;
   logic [W-1:0] load_val;

   generate
      if (CLAMP_MIN) begin : g_clamp
         assign load_val = (val_i == '0) ? W'(1) : val_i;
      end else begin : g_raw
         assign load_val = val_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)            cnt_q <= '0;
      else if (clr_i)          cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
   end

   assign busy_o = (cnt_q != '0);
   assign last_o = (cnt_q == W'(1));

endmodule

// File: rtl/evgate_wdog.sv
module evgate_wdog #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic         start_i,
   input  logic         run_i,
   input  logic [W-1:0] limit_i,
   output logic         expire_o
);

   logic [W-1:0] cnt_q;

   assign expire_o = run_i && (limit_i != '0) && (cnt_q == limit_i - W'(1));

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)                                   cnt_q <= '0;
      else if (start_i)                               cnt_q <= '0;
      else if (run_i && !expire_o && (cnt_q != '1))   cnt_q <= cnt_q + W'(1);
   end

endmodule

// File: rtl/evgate_seq.sv
module evgate_seq #(
   parameter int CNT_W   = 8,
   parameter int WD_W    = 16,
   parameter int CLK_MHZ = 100,
   parameter int TAIL_NS = 1000
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             trig_i,
   input  logic             last_pass_i,
   input  logic             dt_end_i,
   input  logic [CNT_W-1:0] adc_width_i,
   input  logic [CNT_W-1:0] tdc_ext_i,
   input  logic [WD_W-1:0]  wdog_limit_i,
   output logic             veto_n_o,
   output logic             adc_gate_n_o,
   output logic             tdc_gate_n_o,
   output logic             fifo_gate_n_o,
   output logic             wdog_err_o
);
   import evgate_pkg::*;

   localparam int TAIL_CYC = int'(ns_to_cycles(CLK_MHZ, TAIL_NS));
   localparam int TAIL_W   = $clog2(TAIL_CYC + 1);

   generate
      if (TAIL_CYC < 1) begin : g_bad_tail
         $error("veto tail rounds to zero cycles");
      end
      if (CNT_W < 1 || WD_W < 1) begin : g_bad_width
         $error("counter widths must be positive");
      end
   endgenerate

   gate_set_t gates;
   logic busy_q, rd_q, fifo_q, err_q;
   logic accept, lp_ok, abort, adc_end, wd_expire;
   logic adc_busy, adc_last, ext_busy, ext_last, tail_busy, tail_last;

   assign accept  = trig_i && !gates.veto;
   assign lp_ok   = rd_q && last_pass_i;
   assign abort   = wd_expire && !lp_ok;
   assign adc_end = adc_last && !abort;

   evgate_timer #(.W(CNT_W), .CLAMP_MIN(1'b1)) adc_tmr_i (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .clr_i(abort), .load_i(accept),
      .val_i(adc_width_i), .busy_o(adc_busy), .last_o(adc_last));

   evgate_timer #(.W(CNT_W), .CLAMP_MIN(1'b1)) ext_tmr_i (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .clr_i(abort), .load_i(adc_end),
      .val_i(tdc_ext_i), .busy_o(ext_busy), .last_o(ext_last));

   evgate_timer #(.W(TAIL_W), .CLAMP_MIN(1'b0)) tail_tmr_i (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .clr_i(1'b0), .load_i(lp_ok),
      .val_i(TAIL_W'(TAIL_CYC)), .busy_o(tail_busy), .last_o(tail_last));

   evgate_wdog #(.W(WD_W)) wdog_i (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .start_i(accept), .run_i(busy_q),
      .limit_i(wdog_limit_i), .expire_o(wd_expire));

   logic unused_lasts;
   assign unused_lasts = ext_last ^ tail_last;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
         fifo_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (accept)              busy_q <= 1'b1;
         else if (lp_ok || abort) busy_q <= 1'b0;

         if (adc_end)             rd_q <= 1'b1;
         else if (lp_ok || abort) rd_q <= 1'b0;

         if (adc_end)                                  fifo_q <= 1'b1;
         else if (abort || (fifo_q && (lp_ok || dt_end_i))) fifo_q <= 1'b0;

         if (abort)       err_q <= 1'b1;
         else if (accept) err_q <= 1'b0;
      end
   end

   always_comb begin
      gates.adc  = adc_busy;
      gates.tdc  = adc_busy || ext_busy;
      gates.fifo = fifo_q;
      gates.veto = busy_q || tail_busy || adc_busy || ext_busy;
   end

   assign veto_n_o      = ~gates.veto;
   assign adc_gate_n_o  = ~gates.adc;
   assign tdc_gate_n_o  = ~gates.tdc;
   assign fifo_gate_n_o = ~gates.fifo;
   assign wdog_err_o    = err_q;

endmodule

// File: rtl/evgate_seq_chk.sv
module evgate_seq_chk (
   input logic clk_i,
   input logic rst_n_i,
   input logic trig_i,
   input logic last_pass_i,
   input logic dt_end_i,
   input logic veto_n_o,
   input logic adc_gate_n_o,
   input logic tdc_gate_n_o,
   input logic fifo_gate_n_o,
   input logic wdog_err_o
);

   a_r2_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (trig_i && veto_n_o) |=> (!veto_n_o && !adc_gate_n_o && !tdc_gate_n_o));

   a_r8_vetoed_trig: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (trig_i && !veto_n_o && adc_gate_n_o) |=> adc_gate_n_o);

   a_r4_tdc_covers_adc: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !adc_gate_n_o |-> !tdc_gate_n_o);

   a_r4_tdc_outlasts: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ($rose(adc_gate_n_o) && !wdog_err_o) |-> !tdc_gate_n_o);

   a_r5_fifo_follows_adc: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ($rose(adc_gate_n_o) && !wdog_err_o) |-> !fifo_gate_n_o);

   a_r5_fifo_excludes_adc: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !fifo_gate_n_o |-> adc_gate_n_o);

   a_r5_fifo_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!fifo_gate_n_o && !last_pass_i && !dt_end_i) |=> (!fifo_gate_n_o || wdog_err_o));

   a_r7_veto_last: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(veto_n_o) |-> (adc_gate_n_o && tdc_gate_n_o && fifo_gate_n_o));

   a_r9_abort_releases: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(wdog_err_o) |-> (veto_n_o && adc_gate_n_o && tdc_gate_n_o && fifo_gate_n_o));

endmodule

bind evgate_seq evgate_seq_chk chk_i (
   .clk_i(clk_i), .rst_n_i(rst_n_i), .trig_i(trig_i), .last_pass_i(last_pass_i),
   .dt_end_i(dt_end_i), .veto_n_o(veto_n_o), .adc_gate_n_o(adc_gate_n_o),
   .tdc_gate_n_o(tdc_gate_n_o), .fifo_gate_n_o(fifo_gate_n_o), .wdog_err_o(wdog_err_o));

// File: tb/evgate_seq_tb.sv
`timescale 1ns/1ps
module evgate_seq_tb_top;

   localparam int CLK_PERIOD = 100;
   localparam int TAIL       = 10;
   localparam int WIN        = 60;
   localparam int ROWS       = 7;
   // adc width, tdc ext, dt_end index, early last-pass index, last-pass index
   localparam int VEC [ROWS][5] = '{
      '{4, 2, -1, -1, 6},
      '{0, 0, -1, -1, 1},
      '{3, 20, -1, -1, 3},
      '{6, 3, 8, -1, 15},
      '{5, 1, -1, 2, 9},
      '{2, 4, -1, -1, 2},
      '{7, 1, 3, -1, 10}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic trig = 1'b0, last_pass = 1'b0, dt_end = 1'b0;
   logic [7:0]  adc_width = '0, tdc_ext = '0;
   logic [11:0] wd_limit = '0;
   logic veto_n, adc_n, tdc_n, fifo_n, err;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   int c_adc, c_tdc, c_veto, c_fifo, f_fifo, f_err, err_k0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evgate_seq #(.CNT_W(8), .WD_W(12), .CLK_MHZ(10), .TAIL_NS(1000)) dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .trig_i(trig), .last_pass_i(last_pass),
      .dt_end_i(dt_end), .adc_width_i(adc_width), .tdc_ext_i(tdc_ext),
      .wdog_limit_i(wd_limit), .veto_n_o(veto_n), .adc_gate_n_o(adc_n),
      .tdc_gate_n_o(tdc_n), .fifo_gate_n_o(fifo_n), .wdog_err_o(err));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Trigger, then observe WIN negedge samples; k counts edges after acceptance.
   task automatic run_event(input int w, input int e, input int dt_at, input int early_at,
                            input int lp_at, input int rt_at, input int lim);
      adc_width = 8'(w); tdc_ext = 8'(e); wd_limit = 12'(lim);
      c_adc = 0; c_tdc = 0; c_veto = 0; c_fifo = 0; f_fifo = -1; f_err = -1;
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      err_k0 = int'(err);
      for (int k = 0; k < WIN; k++) begin
         if (!adc_n)  c_adc++;
         if (!tdc_n)  c_tdc++;
         if (!veto_n) c_veto++;
         if (!fifo_n) begin c_fifo++; if (f_fifo < 0) f_fifo = k; end
         if (err && f_err < 0) f_err = k;
         last_pass = (k == lp_at) || (k == early_at);
         dt_end    = (k == dt_at);
         trig      = (k == rt_at);
         @(negedge clk);
      end
      last_pass = 1'b0; dt_end = 1'b0; trig = 1'b0;
   endtask

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 veto at reset", int'(veto_n), 1);
      chk("R1 adc at reset", int'(adc_n), 1);
      chk("R1 tdc/fifo at reset", int'(tdc_n & fifo_n), 1);
      chk("R1 err at reset", int'(err), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int r = 0; r < ROWS; r++) begin
         int n, m, rel;
         n = mx(VEC[r][0], 1);
         m = mx(VEC[r][1], 1);
         rel = (VEC[r][2] >= n) ? VEC[r][2] : VEC[r][4];
         run_event(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3], VEC[r][4], -1, 0);
         chk("R3 adc width", c_adc, n);
         chk("R4 tdc width", c_tdc, n + m);
         chk("R5 fifo start", f_fifo, n);
         chk("R5 R6 R10 fifo width", c_fifo, rel - n + 1);
         chk("R7 veto width", c_veto, mx(VEC[r][4] + TAIL + 1, n + m));
      end

      // R8: triggers during the gates and during the tail are ignored
      run_event(3, 1, -1, -1, 5, 1, 0);
      chk("R8 adc unchanged", c_adc, 3);
      chk("R8 veto unchanged", c_veto, 5 + TAIL + 1);
      run_event(3, 1, -1, -1, 5, 10, 0);
      chk("R8 tail trigger adc", c_adc, 3);
      chk("R2 R8 tail trigger veto", c_veto, 16);

      // R9: watchdog abort without last-pass
      run_event(5, 2, -1, -1, -1, -1, 30);
      chk("R9 veto held to limit", c_veto, 30);
      chk("R9 fifo cut at limit", c_fifo, 25);
      chk("R9 err raised", f_err, 30);
      chk("R9 tdc normal", c_tdc, 7);
      run_event(2, 1, -1, -1, 4, -1, 0);
      chk("R9 err cleared on accept", err_k0, 0);
      chk("R2 post-abort event veto", c_veto, 15);
      // R9: last-pass on the limit edge wins
      run_event(3, 1, -1, -1, 19, -1, 20);
      chk("R9 tie no err", f_err, -1);
      chk("R9 tie veto", c_veto, 30);
      // R9: limit 0 disables
      run_event(2, 1, -1, -1, 45, -1, 0);
      chk("R9 disabled no err", f_err, -1);
      chk("R9 disabled veto", c_veto, 56);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule